// File: doc/BRIEF.md
# Dual-Mode Serial Conversion Output Port

This block is the output side of a converter that hands finished 24-bit words to system logic over a serial link. A static mode input selects who owns the shift clock. In self-clocked mode the port divides its master clock to make a shift clock, drives that clock out and pushes the word out without waiting for the host. In external-clock mode the host drives the shift clock and pulls the bits out at its own pace. Chip select and the external clock are asynchronous to the master clock, so both are synchronized before use.

An active-low ready flag tells the host when a word is waiting. The converter core gives two strobes. The conversion-complete strobe comes with a new word. The early-warning strobe arrives shortly before each conversion ends. The port uses these strobes to load, protect or overwrite its output register, and to pulse ready when a word goes unread.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, `rdy_n` is 1 and `sclk_out`, `sdo_oe` and `sclk_oe` are 0 while `cs_n` is high.
- R2: `sdo_oe` is the inverse of `cs_n` seen through a two-flop synchronizer. `sclk_oe` is 1 only when `self_mode` is 1 and the synchronized chip select is low.
- R3: A `conv_done` pulse while no read is in progress loads `conv_word` into the output register and drives `rdy_n` low on the next cycle. `rdy_n` never falls without such a pulse.
- R4: In self-clocked mode (`self_mode`=1), a transfer starts only when chip select is low at the cycle that `conv_done` is taken. The word leaves most significant bit first. Each bit changes on a rising edge of `sclk_out`, and the receiver latches it on the next rising edge, so a full transfer has WORD_W+1 rising edges.
- R5: In self-clocked mode the shift clock period is SCLK_DIV master cycles. `sclk_out` is low whenever no transfer was active in the previous cycle.
- R6: In self-clocked mode, `rdy_n` returns to 1 half a shift-clock period after the last rising edge of the transfer.
- R7: In external-clock mode (`self_mode`=0), `sdo` shows the MSB while a word waits. Each later bit appears after a falling edge of `ext_sclk`. `rdy_n` stays 0 until the WORD_W-th rising edge with chip select low, and then goes to 1.
- R8: A `conv_done` that arrives during a read is discarded, and the word being read comes out intact.
- R9: When a word is waiting and no read has begun, `conv_warn` sets `rdy_n` to 1. The next `conv_done` overwrites the register and drives `rdy_n` low again.
- R10: In self-clocked mode, a word loaded while chip select is high produces no shift clock, even if chip select goes low later.
- R11: `conv_warn` has no effect on `rdy_n` while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| self_mode | input | 1 | 1: port generates shift clock; 0: host drives it |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| ext_sclk | input | 1 | Host shift clock, slower than clk/4 (asynchronous) |
| conv_done | input | 1 | One-cycle strobe: conversion finished, `conv_word` valid |
| conv_word | input | WORD_W | New conversion result |
| conv_warn | input | 1 | One-cycle strobe shortly before a conversion ends |
| sdo | output | 1 | Serial data, MSB first |
| sclk_out | output | 1 | Generated shift clock (self-clocked mode) |
| sdo_oe | output | 1 | Tri-state enable for `sdo` |
| sclk_oe | output | 1 | Tri-state enable for `sclk_out` |
| rdy_n | output | 1 | Active-low word-ready flag |

## Verification
Transfers run in both modes with words that each expose a different fault. Alternating bits catch a shift by one position. A lone LSB and a lone MSB catch a dropped first or last bit. All ones and a counting pattern catch stuck or swapped bits. The port is also driven with the strobe orderings that separate the ready rules: a conversion landing mid-read, a warning with no read, a warning during a read, and a load made while chip select was high in self-clocked mode. The self-clocked run also measures the spacing between clock edges, which separates a wrong divider from a wrong bit count.

// File: rtl/csp_pkg.sv
package csp_pkg;
    typedef enum logic [1:0] {
        PS_EMPTY = 2'd0,
        PS_FULL  = 2'd1,
        PS_BUSY  = 2'd2
    } port_st_e;
endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            hold_q <= RST_VAL;
        end else begin
            meta_q <= din;
            hold_q <= meta_q;
        end
    end

    assign dout = hold_q;
endmodule

// File: rtl/csp_clkgen.sv
module csp_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int HALF  = DIV / 2;
    localparam int CNT_W = $clog2(HALF + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             level;
    } gen_t;

    gen_t g_d, g_q;
    logic wrap;

    assign wrap     = en && (g_q.cnt == TOP);
    assign rise_evt = wrap && !g_q.level;
    assign fall_evt = wrap &&  g_q.level;
    assign sclk     = g_q.level;

    always_comb begin
        g_d = g_q;
        if (!en) begin
            g_d.cnt   = '0;
            g_d.level = 1'b0;
        end else if (wrap) begin
            g_d.cnt   = '0;
            g_d.level = !g_q.level;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
    parameter int WORD_W   = 24,
    parameter int SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              self_mode,
    input  logic              cs_n,
    input  logic              ext_sclk,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_word,
    input  logic              conv_warn,
    output logic              sdo,
    output logic              sclk_out,
    output logic              sdo_oe,
    output logic              sclk_oe,
    output logic              rdy_n
);
    import csp_pkg::*;

    localparam int BIT_W = $clog2(WORD_W + 2);
    localparam logic [BIT_W-1:0] EXT_LAST  = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] SELF_LAST = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] SELF_END  = BIT_W'(WORD_W + 1);

    typedef struct packed {
        port_st_e          st;
        logic              rdy_n;
        logic [WORD_W-1:0] shreg;
        logic [BIT_W-1:0]  bits;
        logic              ext_prev;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0] sync_bus;
    logic       cs_s, ext_s, ext_rise, ext_fall;
    logic       xfer_active, gen_rise, gen_fall, gen_sclk;

    csp_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_sclk, cs_n}),
        .dout (sync_bus)
    );

    assign cs_s     = sync_bus[0];
    assign ext_s    = sync_bus[1];
    assign ext_rise =  ext_s && !r_q.ext_prev;
    assign ext_fall = !ext_s &&  r_q.ext_prev;

    assign xfer_active = (r_q.st == PS_BUSY);

    csp_clkgen #(.DIV(SCLK_DIV)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (xfer_active && self_mode),
        .sclk    (gen_sclk),
        .rise_evt(gen_rise),
        .fall_evt(gen_fall)
    );

    always_comb begin
        r_d          = r_q;
        r_d.ext_prev = ext_s;
        if (r_q.st != PS_BUSY) begin
            if (conv_done) begin
                r_d.shreg = conv_word;
                r_d.rdy_n = 1'b0;
                r_d.bits  = '0;
                r_d.st    = (self_mode && !cs_s) ? PS_BUSY : PS_FULL;
            end else if (r_q.st == PS_FULL && conv_warn) begin
                r_d.rdy_n = 1'b1;
                r_d.st    = PS_EMPTY;
            end else if (r_q.st == PS_FULL && !self_mode && !cs_s && ext_rise) begin
                r_d.st   = PS_BUSY;
                r_d.bits = BIT_W'(1);
            end
        end else if (self_mode) begin
            if (gen_rise) begin
                if (r_q.bits != '0 && r_q.bits <= SELF_LAST) begin
                    r_d.shreg = {r_q.shreg[WORD_W-2:0], 1'b0};
                end
                r_d.bits = r_q.bits + 1'b1;
            end
            if (gen_fall && r_q.bits == SELF_END) begin
                r_d.st    = PS_EMPTY;
                r_d.rdy_n = 1'b1;
            end
        end else if (!cs_s) begin
            if (ext_fall) begin
                r_d.shreg = {r_q.shreg[WORD_W-2:0], 1'b0};
            end
            if (ext_rise) begin
                r_d.bits = r_q.bits + 1'b1;
                if (r_q.bits == EXT_LAST) begin
                    r_d.st    = PS_EMPTY;
                    r_d.rdy_n = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= PS_EMPTY;
            r_q.rdy_n    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo      = r_q.shreg[WORD_W-1];
    assign sclk_out = gen_sclk;
    assign sdo_oe   = !cs_s;
    assign sclk_oe  = self_mode && !cs_s;
    assign rdy_n    = r_q.rdy_n;
endmodule

// File: rtl/csp_port_chk.sv
module csp_port_chk (
    input logic clk,
    input logic rst_n,
    input logic self_mode,
    input logic cs_n,
    input logic conv_done,
    input logic conv_warn,
    input logic sdo_oe,
    input logic sclk_oe,
    input logic sclk_out,
    input logic rdy_n,
    input logic xfer_active
);
    assert_hiz_on_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ##1 (!sdo_oe && !sclk_oe));

    assert_ready_falls_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(conv_done));

    assert_clock_only_in_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |-> $past(xfer_active));

    assert_ready_rises_legally_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> ($past(conv_warn) || $past(xfer_active)));

    assert_ready_held_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> !rdy_n);

    assert_clock_needs_self_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |-> self_mode);
endmodule

bind conv_serial_port csp_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .self_mode  (self_mode),
    .cs_n       (cs_n),
    .conv_done  (conv_done),
    .conv_warn  (conv_warn),
    .sdo_oe     (sdo_oe),
    .sclk_oe    (sclk_oe),
    .sclk_out   (sclk_out),
    .rdy_n      (rdy_n),
    .xfer_active(xfer_active)
);

// File: tb/conv_serial_port_bench.sv
module conv_serial_port_bench;
    localparam int WW  = 24;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          self_mode = 1'b1;
    logic          cs_n = 1'b1;
    logic          ext_sclk = 1'b0;
    logic          conv_done = 1'b0;
    logic [WW-1:0] conv_word = '0;
    logic          conv_warn = 1'b0;
    logic          sdo, sclk_out, sdo_oe, sclk_oe, rdy_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = !clk;

    conv_serial_port #(.WORD_W(WW), .SCLK_DIV(DIV)) u_conv_serial_port (
        .clk(clk), .rst_n(rst_n), .self_mode(self_mode), .cs_n(cs_n),
        .ext_sclk(ext_sclk), .conv_done(conv_done), .conv_word(conv_word),
        .conv_warn(conv_warn), .sdo(sdo), .sclk_out(sclk_out),
        .sdo_oe(sdo_oe), .sclk_oe(sclk_oe), .rdy_n(rdy_n)
    );

    // bit 24: mode (1 = self-clocked), bits 23:0: word
    localparam logic [WW:0] VEC [6] = '{
        {1'b1, 24'hA5C3F0}, {1'b0, 24'h000001}, {1'b1, 24'h800000},
        {1'b0, 24'hFFFFFF}, {1'b1, 24'h123456}, {1'b0, 24'h5A5A5A}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done(input logic [WW-1:0] w);
        conv_word = w; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic pulse_warn;
        conv_warn = 1'b1;
        @(negedge clk);
        conv_warn = 1'b0;
    endtask

    task automatic self_capture(output logic [WW-1:0] w, output int rises, output int pmin, output int pmax);
        logic prev_s = sclk_out;
        logic prev_d = sdo;
        int last = -1;
        int cyc = 0;
        w = '0; rises = 0; pmin = 1000; pmax = 0;
        while (rises < WW + 1 && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (sclk_out && !prev_s) begin
                rises++;
                if (rises >= 2) w = {w[WW-2:0], prev_d};
                if (last >= 0) begin
                    if (cyc - last < pmin) pmin = cyc - last;
                    if (cyc - last > pmax) pmax = cyc - last;
                end
                last = cyc;
            end
            prev_s = sclk_out;
            prev_d = sdo;
        end
    endtask

    task automatic ext_read(input int n, input bit last_chk, inout logic [WW-1:0] w);
        for (int i = 0; i < n; i++) begin
            w = {w[WW-2:0], sdo};
            if (last_chk && i == n - 1)
                chk(rdy_n == 1'b0, "R7 ready low before last edge", 32'(rdy_n), 32'd0);
            ext_sclk = 1'b1; tick(4);
            ext_sclk = 1'b0; tick(4);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
        $finish;
    end

    initial begin
        logic [WW-1:0] w;
        int rises, pmin, pmax, cnt;

        tick(3);
        // R1: reset state
        chk(rdy_n == 1'b1, "R1 rdy_n", 32'(rdy_n), 32'd1);
        chk(!sdo_oe && !sclk_oe && !sclk_out, "R1 enables/clock", {29'd0, sdo_oe, sclk_oe, sclk_out}, 32'd0);
        rst_n = 1'b1;
        tick(3);
        chk(!sdo_oe && !sclk_oe, "R2 deselected hi-z", {30'd0, sdo_oe, sclk_oe}, 32'd0);

        // Vector table: full transfers in both modes
        for (int v = 0; v < 6; v++) begin
            self_mode = VEC[v][WW];
            cs_n = 1'b0;
            tick(4);
            chk(sdo_oe && (sclk_oe == self_mode), "R2 enables", {30'd0, sdo_oe, sclk_oe}, {30'd0, 1'b1, self_mode});
            pulse_done(VEC[v][WW-1:0]);
            if (self_mode) begin
                self_capture(w, rises, pmin, pmax);
                chk(w == VEC[v][WW-1:0], "R4 self word", 32'(w), 32'(VEC[v][WW-1:0]));
                chk(rises == WW + 1, "R4 rising edges", rises, WW + 1);
                chk(pmin == DIV && pmax == DIV, "R5 period", pmin, DIV);
                tick(DIV + 2);
                chk(rdy_n == 1'b1, "R6 ready after transfer", 32'(rdy_n), 32'd1);
                chk(sclk_out == 1'b0, "R5 idle clock low", 32'(sclk_out), 32'd0);
            end else begin
                tick(2);
                chk(rdy_n == 1'b0, "R3 ready low after load", 32'(rdy_n), 32'd0);
                w = '0;
                ext_read(WW, 1'b1, w);
                chk(w == VEC[v][WW-1:0], "R7 ext word", 32'(w), 32'(VEC[v][WW-1:0]));
                chk(rdy_n == 1'b1, "R7 ready after read", 32'(rdy_n), 32'd1);
            end
            cs_n = 1'b1;
            tick(4);
        end

        // R10: self mode load with cs high gives no clock
        self_mode = 1'b1; cs_n = 1'b1; tick(4);
        pulse_done(24'hC0FFEE);
        tick(2);
        chk(rdy_n == 1'b0, "R3 ready low (cs high)", 32'(rdy_n), 32'd0);
        cs_n = 1'b0;
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sclk_out) cnt++;
        end
        chk(cnt == 0, "R10 no clock without start", cnt, 0);
        // R9: warn releases ready, next load restarts
        pulse_warn();
        tick(1);
        chk(rdy_n == 1'b1, "R9 warn raises ready", 32'(rdy_n), 32'd1);
        pulse_done(24'h3C96E1);
        chk(rdy_n == 1'b0, "R9 ready falls on new word", 32'(rdy_n), 32'd0);
        self_capture(w, rises, pmin, pmax);
        chk(w == 24'h3C96E1, "R9 self new word", 32'(w), 32'h3C96E1);
        tick(DIV + 2);

        // R8 / R11: conversion and warn during external read
        self_mode = 1'b0; cs_n = 1'b0; tick(4);
        pulse_done(24'hB1E2D3);
        tick(3);
        w = '0;
        ext_read(5, 1'b0, w);
        pulse_done(24'h0F0F0F);
        pulse_warn();
        tick(2);
        chk(rdy_n == 1'b0, "R11 warn ignored in read", 32'(rdy_n), 32'd0);
        ext_read(WW - 5, 1'b1, w);
        chk(w == 24'hB1E2D3, "R8 word kept intact", 32'(w), 32'hB1E2D3);
        chk(rdy_n == 1'b1, "R7 ready after read", 32'(rdy_n), 32'd1);

        // R9 external: unread word overwritten
        pulse_done(24'h111111);
        tick(2);
        chk(sdo == 1'b0, "R7 MSB presented", 32'(sdo), 32'd0);
        pulse_warn();
        tick(1);
        chk(rdy_n == 1'b1, "R9 warn raises ready (ext)", 32'(rdy_n), 32'd1);
        pulse_done(24'hE4D2C1);
        chk(rdy_n == 1'b0, "R9 ready falls again", 32'(rdy_n), 32'd0);
        tick(2);
        w = '0;
        ext_read(WW, 1'b1, w);
        chk(w == 24'hE4D2C1, "R9 overwrite word", 32'(w), 32'hE4D2C1);

        // R2: external mode never enables clock output
        chk(sdo_oe && !sclk_oe, "R2 ext enables", {30'd0, sdo_oe, sclk_oe}, 32'd2);
        cs_n = 1'b1; tick(3);
        chk(!sdo_oe && !sclk_oe, "R2 hi-z on deselect", {30'd0, sdo_oe, sclk_oe}, 32'd0);

        summary();
        $finish;
    end
endmodule